// File: doc/BRIEF.md
# Condition Register Field Move Unit

This block holds a 32-bit condition register made of eight 4-bit fields. It carries out the field-oriented transfers between that register, a 64-bit general-purpose operand, and four carry/overflow flags. Each request carries the following:
- an operation code,
- an 8-bit field mask,
- a 3-bit field index,
- a 64-bit source operand,
- the flags OV, OV32, CA and CA32.

The block returns a 64-bit result in the same cycle. When the operation is a write, it updates the register at the next rising clock edge.

Bit numbering follows the MSB-0 convention of the surrounding datapath. Field n (0 to 7) sits at bits 4n+32 to 4n+35 of the 64-bit view. In LSB-0 terms that is `[31-4n -: 4]`, so field 0 is the top nibble of the register. Mask bit FXM[n] selects field n and is carried on port bit `req_mask[7-n]`, which makes FXM[0] the most significant bit of the mask.

The request side is a valid/ready stream that never applies back-pressure: `req_ready` is constantly high, and every request with `req_valid` high is accepted in the cycle it is presented. The response has no buffering. `rsp_valid` mirrors `req_valid`, and `rsp_data` is a combinational function of the request and of the register contents before the edge that accepts it.

Top module: `crf_move_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the register to zero, so a full read issued right after reset returns 0.
- R2: Operation code 0 (masked write) replaces every field n whose mask bit `req_mask[7-n]` is 1 with bits `[31-4n -: 4]` of `req_src`. All other fields keep their value, and an all-zero mask changes nothing.
- R3: Operation code 1 (single-field write) copies from `req_src` only the lowest-numbered field whose mask bit is set. Every other field is kept, including higher-numbered fields that are also selected.
- R4: A single-field write with an all-zero mask writes field 7 (register bits `[3:0]`).
- R5: Operation code 2 (flag copy) writes field `req_idx` with {OV, OV32, CA, CA32}, OV in the most significant bit. The other fields are kept.
- R6: Operation code 3 (single-field read) returns zeros everywhere except the lowest-numbered field whose mask bit is set. That field appears at its own position `[31-4n -: 4]` of `rsp_data`.
- R7: A single-field read with an all-zero mask returns 0.
- R8: Operation code 4 (full read) returns 32 zero bits above the 32-bit register.
- R9: The register changes only on a rising edge that accepts a write request. With `req_valid` low, or for a read, it holds. A result always reflects the register as it was before that edge.
- R10: Write operations and the unused codes 5 to 7 return 0 on `rsp_data`. The unused codes leave the register unchanged.
- R11: `req_ready` is always 1, and `rsp_valid` equals `req_valid` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_op | input | 3 | Operation code (0 to 4 defined) |
| req_mask | input | 8 | Field mask, bit 7-n selects field n |
| req_idx | input | 3 | Field index for the flag copy |
| req_src | input | 64 | Source operand |
| flag_ov | input | 1 | Overflow flag |
| flag_ov32 | input | 1 | 32-bit overflow flag |
| flag_ca | input | 1 | Carry flag |
| flag_ca32 | input | 1 | 32-bit carry flag |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_data | output | 64 | Result |

## Verification
The hardest case to reach is a mask that selects several fields at once under the single-field forms. Only the lowest-numbered selected field may move, and a fault that writes or returns a higher selected field would go unnoticed if the higher fields held the same nibble. The stimulus therefore first loads a register in which every field differs, using a full masked write. It then issues single-field writes and reads with multi-bit masks whose lowest set bit sits in the middle of the mask, and follows each write with a full read. A pseudo-random phase then interleaves all codes, including the unused ones and idle cycles that carry write-like data, against a bench model of the register.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef enum logic [2:0] {
    CRF_OP_MASK_WR = 3'd0,
    CRF_OP_ONE_WR  = 3'd1,
    CRF_OP_FLAG_WR = 3'd2,
    CRF_OP_ONE_RD  = 3'd3,
    CRF_OP_ALL_RD  = 3'd4
  } crf_op_e;

  function automatic logic op_is_write(input logic [2:0] op);
    return (op == CRF_OP_MASK_WR) || (op == CRF_OP_ONE_WR) || (op == CRF_OP_FLAG_WR);
  endfunction

endpackage

// File: rtl/crf_prio_pick.sv
// Picks the lowest-numbered field whose select bit is set.
// With nothing selected it reports the highest field and found = 0.
module crf_prio_pick #(
  parameter int NFLD = 8,
  localparam int IDXW = $clog2(NFLD)
) (
  input  logic [NFLD-1:0] sel,
  output logic [IDXW-1:0] idx,
  output logic            found
);

  always_comb begin
    idx   = IDXW'(NFLD - 1);
    found = 1'b0;
    for (int i = NFLD - 1; i >= 0; i--) begin
      if (sel[i]) begin
        idx   = IDXW'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/crf_write_path.sv
// Next-state computation for the condition register, one field at a time.
module crf_write_path
  import crf_pkg::*;
#(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  localparam int CRW  = NFLD * FW,
  localparam int IDXW = $clog2(NFLD)
) (
  input  logic [2:0]      op,
  input  logic [CRW-1:0]  cr_cur,
  input  logic [CRW-1:0]  src,
  input  logic [NFLD-1:0] fsel,
  input  logic [IDXW-1:0] pick_idx,
  input  logic [IDXW-1:0] flag_idx,
  input  logic [FW-1:0]   flags,
  output logic [CRW-1:0]  cr_next,
  output logic            wr_en
);

  assign wr_en = op_is_write(op);

  for (genvar n = 0; n < NFLD; n++) begin : g_fld
    localparam int HI = CRW - 1 - FW * n;
    logic          upd;
    logic [FW-1:0] data;

    always_comb begin
      unique case (op)
        CRF_OP_MASK_WR: upd = fsel[n];
        CRF_OP_ONE_WR:  upd = (pick_idx == IDXW'(n));
        CRF_OP_FLAG_WR: upd = (flag_idx == IDXW'(n));
        default:        upd = 1'b0;
      endcase
      data = (op == CRF_OP_FLAG_WR) ? flags : src[HI -: FW];
    end

    assign cr_next[HI -: FW] = upd ? data : cr_cur[HI -: FW];
  end

endmodule

// File: rtl/crf_read_path.sv
// Result formation for the read operations.
module crf_read_path
  import crf_pkg::*;
#(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int DW   = 64,
  localparam int CRW  = NFLD * FW,
  localparam int IDXW = $clog2(NFLD)
) (
  input  logic [2:0]      op,
  input  logic [CRW-1:0]  cr_cur,
  input  logic [IDXW-1:0] pick_idx,
  input  logic            found,
  output logic [DW-1:0]   result
);

  logic [CRW-1:0] one_fld;

  for (genvar n = 0; n < NFLD; n++) begin : g_rd
    localparam int HI = CRW - 1 - FW * n;
    assign one_fld[HI -: FW] = (found && pick_idx == IDXW'(n)) ? cr_cur[HI -: FW] : '0;
  end

  always_comb begin
    unique case (op)
      CRF_OP_ONE_RD: result = {{(DW-CRW){1'b0}}, one_fld};
      CRF_OP_ALL_RD: result = {{(DW-CRW){1'b0}}, cr_cur};
      default:       result = '0;
    endcase
  end

endmodule

// File: rtl/crf_move_unit.sv
// Condition register field move unit: top level.
module crf_move_unit #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int DW   = 64,
  localparam int CRW  = NFLD * FW,
  localparam int IDXW = $clog2(NFLD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [NFLD-1:0] req_mask,
  input  logic [IDXW-1:0] req_idx,
  input  logic [DW-1:0]   req_src,
  input  logic            flag_ov,
  input  logic            flag_ov32,
  input  logic            flag_ca,
  input  logic            flag_ca32,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data
);

  logic [CRW-1:0]  cr_q;
  logic [CRW-1:0]  cr_d;
  logic            wr_en;
  logic [NFLD-1:0] fsel;
  logic [IDXW-1:0] pick_idx;
  logic            found;
  logic [FW-1:0]   flags;
  logic            unused_src_hi;

  // Mask bit 0 (MSB-0) is the top port bit; re-index so fsel[n] means field n.
  for (genvar n = 0; n < NFLD; n++) begin : g_sel
    assign fsel[n] = req_mask[NFLD-1-n];
  end

  assign flags         = {flag_ov, flag_ov32, flag_ca, flag_ca32};
  assign unused_src_hi = ^req_src[DW-1:CRW];

  crf_prio_pick #(.NFLD(NFLD)) u_pick (
    .sel   (fsel),
    .idx   (pick_idx),
    .found (found)
  );

  crf_write_path #(.NFLD(NFLD), .FW(FW)) u_wr (
    .op       (req_op),
    .cr_cur   (cr_q),
    .src      (req_src[CRW-1:0]),
    .fsel     (fsel),
    .pick_idx (pick_idx),
    .flag_idx (req_idx),
    .flags    (flags),
    .cr_next  (cr_d),
    .wr_en    (wr_en)
  );

  crf_read_path #(.NFLD(NFLD), .FW(FW), .DW(DW)) u_rd (
    .op       (req_op),
    .cr_cur   (cr_q),
    .pick_idx (pick_idx),
    .found    (found),
    .result   (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                     cr_q <= '0;
    else if (req_valid && wr_en) cr_q <= cr_d;
  end

  assign req_ready = 1'b1;
  assign rsp_valid = req_valid;

endmodule

// File: rtl/crf_move_unit_chk.sv
module crf_move_unit_chk #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int DW   = 64,
  localparam int CRW  = NFLD * FW,
  localparam int IDXW = $clog2(NFLD)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic [NFLD-1:0] req_mask,
  input logic [IDXW-1:0] req_idx,
  input logic [FW-1:0]   req_src_lo,
  input logic [FW-1:0]   flags,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_data,
  input logic [CRW-1:0]  cr_q
);

  function automatic logic [FW-1:0] fld_of(input logic [CRW-1:0] cr, input logic [IDXW-1:0] i);
    logic [CRW-1:0] sh;
    sh = cr >> (FW * (NFLD - 1 - int'(i)));
    return sh[FW-1:0];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cr_q == '0); // R1

  AST_MASK_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd0 && req_mask == '0) |=> $stable(cr_q)); // R2

  AST_ONE_WR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd1 && req_mask == '0) |=>
      (cr_q[CRW-1:FW] == $past(cr_q[CRW-1:FW]) && cr_q[FW-1:0] == $past(req_src_lo))); // R4

  AST_FLAG_FIELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd2) |=> fld_of(cr_q, $past(req_idx)) == $past(flags)); // R5

  AST_ONE_RD_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3) |->
      (rsp_data[DW-1:CRW] == '0 && (rsp_data[CRW-1:0] & ~cr_q) == '0)); // R6

  AST_ONE_RD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3 && req_mask == '0) |-> rsp_data == '0); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(cr_q)); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd3 || req_op == 3'd4)) |=> $stable(cr_q)); // R9

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op > 3'd4) |=> ($stable(cr_q) && $past(rsp_data) == '0)); // R10

  AST_STREAM_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_ready && rsp_valid == req_valid)); // R11

endmodule

bind crf_move_unit crf_move_unit_chk #(.NFLD(NFLD), .FW(FW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_mask   (req_mask),
  .req_idx    (req_idx),
  .req_src_lo (req_src[FW-1:0]),
  .flags      (flags),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .cr_q       (cr_q)
);

// File: tb/crf_move_unit_tb.sv
module crf_move_unit_tb;

  localparam int CLK_P = 10;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_mask = '0;
  logic [2:0]  req_idx = '0;
  logic [63:0] req_src = '0;
  logic        flag_ov = 1'b0, flag_ov32 = 1'b0, flag_ca = 1'b0, flag_ca32 = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  item_t sb_q[$];
  logic [31:0] model_cr = '0;

  always #(CLK_P/2) clk = ~clk;

  crf_move_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mask(req_mask), .req_idx(req_idx), .req_src(req_src),
    .flag_ov(flag_ov), .flag_ov32(flag_ov32), .flag_ca(flag_ca), .flag_ca32(flag_ca32),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // Lowest-numbered field n with mask bit FXM[n] = req_mask[7-n]; -1 if none.
  function automatic int first_fld(input logic [7:0] m);
    for (int n = 0; n < 8; n++) if (m[7-n]) return n;
    return -1;
  endfunction

  function automatic logic [63:0] model_result(input logic [2:0] op, input logic [7:0] m,
                                               input logic [31:0] cr);
    logic [63:0] r;
    int f;
    r = '0;
    if (op == 3'd4) r = {32'h0, cr};
    else if (op == 3'd3) begin
      f = first_fld(m);
      if (f >= 0) for (int b = 0; b < 4; b++) r[28-4*f+b] = cr[28-4*f+b];
    end
    return r;
  endfunction

  function automatic logic [31:0] model_next(input logic [2:0] op, input logic [7:0] m,
                                             input logic [2:0] idx, input logic [63:0] s,
                                             input logic [3:0] fl, input logic [31:0] cr);
    logic [31:0] c;
    int f;
    c = cr;
    case (op)
      3'd0: for (int n = 0; n < 8; n++) if (m[7-n]) c[28-4*n +: 4] = s[28-4*n +: 4];
      3'd1: begin
        f = first_fld(m);
        if (f < 0) f = 7;
        c[28-4*f +: 4] = s[28-4*f +: 4];
      end
      3'd2: c[28-4*int'(idx) +: 4] = fl;
      default: ;
    endcase
    return c;
  endfunction

  task automatic drive(input logic v, input logic [2:0] op, input logic [7:0] m,
                       input logic [2:0] idx, input logic [63:0] s, input logic [3:0] fl,
                       input string tag);
    item_t it;
    @(negedge clk);
    req_valid = v; req_op = op; req_mask = m; req_idx = idx; req_src = s;
    {flag_ov, flag_ov32, flag_ca, flag_ca32} = fl;
    if (v) begin
      it.exp = model_result(op, m, model_cr);
      it.tag = tag;
      sb_q.push_back(it);
      model_cr = model_next(op, m, idx, s, fl, model_cr);
    end
  endtask

  task automatic full_read(input string tag);
    drive(1'b1, 3'd4, 8'h00, 3'd0, 64'h0, 4'h0, tag);
  endtask

  // Monitor: samples a quarter period after the driving edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (!rst) begin
        n_tests++;
        if (!(req_ready === 1'b1 && rsp_valid === req_valid)) begin
          n_fail++;
          $display("FAIL R11 ready=%b valid=%b expected ready=1 valid=%b",
                   req_ready, rsp_valid, req_valid);
        end
        if (req_valid) begin
          if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty actual=%h expected=<item>", rsp_data);
          end else begin
            it = sb_q.pop_front();
            n_tests++;
            if (rsp_data !== it.exp) begin
              n_fail++;
              $display("FAIL %s actual=%h expected=%h", it.tag, rsp_data, it.exp);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    full_read("R1 reset value");

    drive(1'b1, 3'd0, 8'hFF, 3'd0, 64'hDEAD_BEEF_1234_5678, 4'h0, "R2 full mask write");
    full_read("R2 R8 readback 12345678");
    drive(1'b1, 3'd0, 8'b1010_0000, 3'd0, 64'hFFFF_FFFF_9ABC_DEF0, 4'h0, "R2 fields 0,2");
    full_read("R2 readback 92B45678");
    drive(1'b1, 3'd0, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, "R2 empty mask");
    full_read("R2 empty mask keeps");

    drive(1'b1, 3'd1, 8'b0011_0101, 3'd0, 64'h0000_0000_FFFF_FFFF, 4'h0, "R3 lowest of 2,3,5,7");
    full_read("R3 readback 92F45678");
    drive(1'b1, 3'd1, 8'h00, 3'd0, 64'h0000_0000_0000_000A, 4'h0, "R4 default field 7");
    full_read("R4 readback 92F4567A");

    drive(1'b1, 3'd2, 8'hFF, 3'd3, 64'h0, 4'b1011, "R5 flags to field 3");
    drive(1'b1, 3'd2, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0110, "R5 flags to field 0");
    drive(1'b1, 3'd2, 8'h00, 3'd7, 64'h0, 4'b0001, "R5 flags to field 7");
    full_read("R5 readback 62FB5671");

    drive(1'b1, 3'd3, 8'b0000_1001, 3'd0, 64'h0, 4'h0, "R6 read field 4 of 4,7");
    drive(1'b1, 3'd3, 8'h80, 3'd0, 64'h0, 4'h0, "R6 read field 0");
    drive(1'b1, 3'd3, 8'b0001_1111, 3'd0, 64'h0, 4'h0, "R6 read field 3 of 3..7");
    drive(1'b1, 3'd3, 8'h00, 3'd0, 64'h0, 4'h0, "R7 empty mask read");

    drive(1'b1, 3'd5, 8'hFF, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, "R10 unused code 5");
    drive(1'b1, 3'd7, 8'hFF, 3'd2, 64'h0, 4'hF, "R10 unused code 7");
    full_read("R10 register unchanged");
    drive(1'b0, 3'd0, 8'hFF, 3'd0, 64'h0, 4'h0, "R9 idle");
    drive(1'b0, 3'd2, 8'hFF, 3'd1, 64'h0, 4'hF, "R9 idle");
    full_read("R9 idle keeps register");

    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 80; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      drive(lf[31], 3'(lf[2:0] % 3'd6 + ((lf[30] & lf[29]) ? 3'd0 : 3'd0)), lf[15:8],
            lf[18:16], {lf, lf ^ 32'h5A5A_A5A5}, lf[23:20], "R2 R3 R5 R6 R8 R9 mixed");
      if (k % 8 == 7) full_read("R8 R9 mixed readback");
    end

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule